// File: doc/BRIEF.md
# Ethernet Frame Tag Inserter and Head Trimmer

This block edits Ethernet frames on their way to an encapsulation stage. It receives a frame one byte at a time on a streaming input with first-byte and last-byte markers and a ready/valid handshake. It produces the edited frame on an output of the same kind. All edits happen in one pass and in the same clock cycle as the handshake, so no byte is held longer than the edits require.

Three edits are available. The trailing 4-byte Ethernet check sequence can be kept or stripped. When it is stripped, the last-byte marker moves onto the final payload byte. A fixed run of leading bytes can be cut off: 18 or 14 bytes, counted from the destination address. A 4-byte tag can be inserted ahead of the first remaining byte, and a second 4-byte tag can be inserted right behind the source address. The tag values come from pairs of 16-bit configuration inputs.

The configuration is taken in the cycle that the first byte of a frame is accepted. It then applies to that whole frame, even if the inputs change while the frame is in flight.

Top module: `frame_tag_trimmer`

## Requirements
- R1: With `cfg_trim` = 00, `cfg_fcs_keep` = 1 and both tags disabled, every byte is forwarded unchanged. The first-byte and last-byte markers stay on the same bytes.
- R2: `cfg_trim` = 01 drops the first 18 bytes of each frame. The first-byte marker moves to the 19th input byte.
- R3: `cfg_trim` = 10 drops the first 14 bytes. The reserved code 11 behaves exactly like 00.
- R4: With `cfg_tag1_en` = 1, four tag bytes are emitted before the first remaining byte of the frame, in the order `cfg_tag1_hi[15:8]`, `cfg_tag1_hi[7:0]`, `cfg_tag1_lo[15:8]`, `cfg_tag1_lo[7:0]`. The first tag byte carries the first-byte marker.
- R5: With `cfg_tag2_en` = 1 and no trimming, the four bytes of tag 2 (same byte order) are emitted after the 12th byte of the frame. This happens only if a 13th byte (after any stripping) exists.
- R6: With `cfg_fcs_keep` = 0, the last 4 bytes of each frame are removed and the last-byte marker is placed on the byte before them. A frame of 4 bytes or fewer produces no output. With `cfg_fcs_keep` = 1, the final bytes are forwarded.
- R7: When 18 or 14 bytes are trimmed, tag 2 is never inserted. Tag 1 still precedes the first remaining byte.
- R8: All configuration inputs are sampled when the first byte of a frame is accepted. Changes during the frame do not alter that frame.
- R9: Under output backpressure, no byte is lost, duplicated or reordered. Each output frame carries exactly one first-byte marker, on its first byte. After reset the output is idle and the input is ready.
- R10: A frame that trimming consumes entirely produces no output at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| cfg_trim | input | 2 | Head trim: 00 none, 01 18 bytes, 10 14 bytes, 11 none |
| cfg_tag1_en | input | 1 | Insert tag 1 before the first remaining byte |
| cfg_tag2_en | input | 1 | Insert tag 2 after the source address |
| cfg_fcs_keep | input | 1 | 1 forwards the trailing check sequence, 0 strips it |
| cfg_tag1_hi | input | 16 | Tag 1 upper half |
| cfg_tag1_lo | input | 16 | Tag 1 lower half |
| cfg_tag2_hi | input | 16 | Tag 2 upper half |
| cfg_tag2_lo | input | 16 | Tag 2 lower half |

## Verification
The assertions are checked on every cycle. They cover the following: the output framing (a first-byte marker on exactly the first byte of each frame); the fill bound of the strip delay line and its emptying when a frame ends; and the fact that a tag burst stalls the input and ends after exactly four bytes. Only the directed scenarios can show whether the right bytes leave the block. That includes trim lengths, tag positions and byte order, the moved last-byte marker, tag 2 being skipped under trimming, and whole frames vanishing. It also includes configuration being held across a frame and exact ordering under random backpressure.

// File: rtl/tagtrim_pkg.sv
package tagtrim_pkg;

    localparam int BYTE_W     = 8;
    localparam int FCS_LEN    = 4;
    localparam int TAG_LEN    = 4;
    localparam int TAG2_AFTER = 12;
    localparam int POS_W      = 5;
    localparam int TAG_W      = BYTE_W * TAG_LEN;
    localparam int HALF_W     = TAG_W / 2;

    typedef enum logic [1:0] {
        TRIM_OFF   = 2'b00,
        TRIM_LONG  = 2'b01,
        TRIM_SHORT = 2'b10,
        TRIM_RSVD  = 2'b11
    } trim_mode_e;

    typedef struct packed {
        trim_mode_e         trim;
        logic               tag1_en;
        logic               tag2_en;
        logic               fcs_keep;
        logic [TAG_W-1:0]   tag1;
        logic [TAG_W-1:0]   tag2;
    } edit_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0]  data;
        logic               sof;
        logic               eof;
    } beat_t;

    // Number of leading bytes removed for a trim code; reserved acts as none.
    function automatic logic [POS_W-1:0] trim_count(trim_mode_e m);
        case (m)
            TRIM_LONG:  return POS_W'(18);
            TRIM_SHORT: return POS_W'(14);
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/tt_fcs_strip.sv
module tt_fcs_strip
    import tagtrim_pkg::*;
#(
    parameter int DEPTH = FCS_LEN
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  keep,
    input  logic  in_valid,
    output logic  in_ready,
    input  beat_t in_beat,
    output logic  out_valid,
    input  logic  out_ready,
    output beat_t out_beat
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DEPTH-1:0][BYTE_W-1:0] dly_data;
    logic [DEPTH-1:0]             dly_sof;
    logic [CW-1:0]                fill;
    logic                         full;
    logic                         in_fire;

    assign full    = (fill == FULL_CNT);
    assign in_fire = in_valid && in_ready;

    always_comb begin
        if (keep) begin
            out_valid = in_valid;
            out_beat  = in_beat;
            in_ready  = out_ready;
        end else begin
            // The oldest held byte leaves only when a newer one arrives,
            // so the final DEPTH bytes of a frame never leave.
            out_valid     = in_valid && full;
            out_beat.data = dly_data[0];
            out_beat.sof  = dly_sof[0];
            out_beat.eof  = in_beat.eof;
            in_ready      = !full || out_ready;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill     <= '0;
            dly_data <= '0;
            dly_sof  <= '0;
        end else if (in_fire && !keep) begin
            if (in_beat.eof) begin
                fill <= '0;
            end else if (full) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    dly_data[i] <= dly_data[i+1];
                    dly_sof[i]  <= dly_sof[i+1];
                end
                dly_data[DEPTH-1] <= in_beat.data;
                dly_sof[DEPTH-1]  <= in_beat.sof;
            end else begin
                dly_data[fill[IW-1:0]] <= in_beat.data;
                dly_sof[fill[IW-1:0]]  <= in_beat.sof;
                fill                   <= fill + 1'b1;
            end
        end
    end

    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL_CNT);

    assert_flush_on_end_R6: assert property (@(posedge clk) disable iff (rst)
        (in_fire && !keep && in_beat.eof) |=> (fill == '0));

endmodule

// File: rtl/tt_head_trim.sv
module tt_head_trim
    import tagtrim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trim_mode_e mode,
    input  logic       in_valid,
    output logic       in_ready,
    input  beat_t      in_beat,
    output logic       out_valid,
    input  logic       out_ready,
    output beat_t      out_beat
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] idx;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] cut;
    logic             drop;

    assign cut  = trim_count(mode);
    assign pos  = in_beat.sof ? '0 : idx;
    assign drop = (pos < cut);

    always_comb begin
        out_valid     = in_valid && !drop;
        in_ready      = drop || out_ready;
        out_beat.data = in_beat.data;
        out_beat.sof  = (pos == cut);
        out_beat.eof  = in_beat.eof;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (in_valid && in_ready) begin
            if (in_beat.eof)         idx <= '0;
            else if (pos != POS_MAX) idx <= pos + 1'b1;
            else                     idx <= pos;
        end
    end

    assert_trimmed_hidden_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && drop) |-> (!out_valid && in_ready));

endmodule

// File: rtl/tt_tag_insert.sv
module tt_tag_insert
    import tagtrim_pkg::*;
#(
    parameter int TAGB  = TAG_LEN,
    parameter int AFTER = TAG2_AFTER
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tag1_en,
    input  logic                  tag2_on,
    input  logic [BYTE_W*TAGB-1:0] tag1_val,
    input  logic [BYTE_W*TAGB-1:0] tag2_val,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  beat_t                 in_beat,
    output logic                  out_valid,
    input  logic                  out_ready,
    output beat_t                 out_beat
);
    localparam int KW = (TAGB > 1) ? $clog2(TAGB) : 1;
    localparam int CW = $clog2(AFTER + 1);
    localparam logic [KW-1:0] K_LAST = KW'(TAGB - 1);
    localparam logic [CW-1:0] C_HIT  = CW'(AFTER);

    logic          in_t1, in_t2;
    logic          t1_sent, t2_sent;
    logic [KW-1:0] k;
    logic [CW-1:0] seen;
    logic          start1, start2, emit1, emit2, out_fire;

    function automatic logic [BYTE_W-1:0] octet(logic [BYTE_W*TAGB-1:0] v,
                                                logic [KW-1:0] n);
        return BYTE_W'(v >> (BYTE_W * (TAGB - 1 - int'(n))));
    endfunction

    assign start1 = !in_t1 && !in_t2 && in_valid && in_beat.sof
                    && tag1_en && !t1_sent;
    assign start2 = !in_t1 && !in_t2 && in_valid && !in_beat.sof
                    && tag2_on && !t2_sent && (seen == C_HIT);
    assign emit1  = in_t1 || start1;
    assign emit2  = in_t2 || start2;
    assign out_fire = out_valid && out_ready;

    always_comb begin
        if (emit1) begin
            out_valid     = 1'b1;
            out_beat.data = octet(tag1_val, k);
            out_beat.sof  = (k == '0);
            out_beat.eof  = 1'b0;
            in_ready      = 1'b0;
        end else if (emit2) begin
            out_valid     = 1'b1;
            out_beat.data = octet(tag2_val, k);
            out_beat.sof  = 1'b0;
            out_beat.eof  = 1'b0;
            in_ready      = 1'b0;
        end else begin
            out_valid     = in_valid;
            out_beat.data = in_beat.data;
            out_beat.sof  = in_beat.sof && !t1_sent;
            out_beat.eof  = in_beat.eof;
            in_ready      = out_ready;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_t1   <= 1'b0;
            in_t2   <= 1'b0;
            t1_sent <= 1'b0;
            t2_sent <= 1'b0;
            k       <= '0;
            seen    <= '0;
        end else if (emit1) begin
            if (out_fire && k == K_LAST) begin
                k       <= '0;
                in_t1   <= 1'b0;
                t1_sent <= 1'b1;
            end else begin
                if (out_fire) k <= k + 1'b1;
                in_t1 <= 1'b1;
            end
        end else if (emit2) begin
            if (out_fire && k == K_LAST) begin
                k       <= '0;
                in_t2   <= 1'b0;
                t2_sent <= 1'b1;
            end else begin
                if (out_fire) k <= k + 1'b1;
                in_t2 <= 1'b1;
            end
        end else if (in_valid && in_ready) begin
            if (in_beat.eof) begin
                seen    <= '0;
                t1_sent <= 1'b0;
                t2_sent <= 1'b0;
            end else if (seen != C_HIT) begin
                seen <= seen + 1'b1;
            end
        end
    end

    assert_tag_stalls_input_R4: assert property (@(posedge clk) disable iff (rst)
        (in_t1 || in_t2) |-> (out_valid && !in_ready));

    assert_tag1_four_bytes_R4: assert property (@(posedge clk) disable iff (rst)
        (in_t1 && out_fire && k == K_LAST) |=> (!in_t1 && t1_sent));

    assert_tag2_after_head_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(in_t2) |-> (seen == C_HIT));

endmodule

// File: rtl/frame_tag_trimmer.sv
module frame_tag_trimmer
    import tagtrim_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_sof,
    output logic        out_eof,
    input  logic [1:0]  cfg_trim,
    input  logic        cfg_tag1_en,
    input  logic        cfg_tag2_en,
    input  logic        cfg_fcs_keep,
    input  logic [15:0] cfg_tag1_hi,
    input  logic [15:0] cfg_tag1_lo,
    input  logic [15:0] cfg_tag2_hi,
    input  logic [15:0] cfg_tag2_lo
);
    edit_cfg_t live_cfg, held_cfg, cfg_eff;
    logic      in_open, out_open;
    logic      tag2_on;

    beat_t src_beat, s1_beat, s2_beat, s3_beat;
    logic  s1_valid, s1_ready, s2_valid, s2_ready;

    always_comb begin
        live_cfg.trim     = trim_mode_e'(cfg_trim);
        live_cfg.tag1_en  = cfg_tag1_en;
        live_cfg.tag2_en  = cfg_tag2_en;
        live_cfg.fcs_keep = cfg_fcs_keep;
        live_cfg.tag1     = {cfg_tag1_hi, cfg_tag1_lo};
        live_cfg.tag2     = {cfg_tag2_hi, cfg_tag2_lo};
    end

    // Inside a frame the copy taken at its first byte governs every stage.
    assign cfg_eff = in_open ? held_cfg : live_cfg;
    assign tag2_on = cfg_eff.tag2_en && (trim_count(cfg_eff.trim) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_open  <= 1'b0;
            held_cfg <= '0;
        end else if (in_valid && in_ready) begin
            if (in_sof && !in_open) held_cfg <= live_cfg;
            if (in_eof)             in_open  <= 1'b0;
            else if (in_sof)        in_open  <= 1'b1;
        end
    end

    assign src_beat = '{data: in_data, sof: in_sof, eof: in_eof};

    tt_fcs_strip #(.DEPTH(FCS_LEN)) u_strip (
        .clk       (clk),
        .rst       (rst),
        .keep      (cfg_eff.fcs_keep),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_beat   (src_beat),
        .out_valid (s1_valid),
        .out_ready (s1_ready),
        .out_beat  (s1_beat)
    );

    tt_head_trim u_trim (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_eff.trim),
        .in_valid  (s1_valid),
        .in_ready  (s1_ready),
        .in_beat   (s1_beat),
        .out_valid (s2_valid),
        .out_ready (s2_ready),
        .out_beat  (s2_beat)
    );

    tt_tag_insert #(.TAGB(TAG_LEN), .AFTER(TAG2_AFTER)) u_ins (
        .clk       (clk),
        .rst       (rst),
        .tag1_en   (cfg_eff.tag1_en),
        .tag2_on   (tag2_on),
        .tag1_val  (cfg_eff.tag1),
        .tag2_val  (cfg_eff.tag2),
        .in_valid  (s2_valid),
        .in_ready  (s2_ready),
        .in_beat   (s2_beat),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_beat  (s3_beat)
    );

    assign out_data = s3_beat.data;
    assign out_sof  = s3_beat.sof;
    assign out_eof  = s3_beat.eof;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_open <= 1'b0;
        end else if (out_valid && out_ready) begin
            out_open <= !out_eof;
        end
    end

    assert_frame_opens_with_sof_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_open) |-> out_sof);

    assert_no_inner_sof_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_open) |-> !out_sof);

endmodule

// File: tb/frame_tag_trimmer_test.sv
`timescale 1ns/1ps
module frame_tag_trimmer_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, out_valid, out_sof, out_eof;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic [1:0]  c_trim = 2'b00;
    logic        c_t1 = 0, c_t2 = 0, c_keep = 1;
    logic [15:0] c_t1hi = 16'hA1B2, c_t1lo = 16'hC3D4;
    logic [15:0] c_t2hi = 16'h5566, c_t2lo = 16'h7788;

    frame_tag_trimmer uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof),
        .cfg_trim(c_trim), .cfg_tag1_en(c_t1), .cfg_tag2_en(c_t2),
        .cfg_fcs_keep(c_keep),
        .cfg_tag1_hi(c_t1hi), .cfg_tag1_lo(c_t1lo),
        .cfg_tag2_hi(c_t2hi), .cfg_tag2_lo(c_t2lo)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    bit bp_on = 0;
    logic [7:0] lfsr = 8'hA5;
    logic [7:0] frm[$];
    logic [9:0] exp_q[$];
    logic [9:0] obs_q[$];

    always begin
        @(posedge clk); #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = bp_on ? lfsr[0] : 1'b1;
    end

    always @(negedge clk)
        if (!rst && out_valid && out_ready)
            obs_q.push_back({out_sof, out_eof, out_data});

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Reference edit of the frame held in frm, from the requirements.
    task automatic build_expect();
        logic [7:0] s[$];
        logic [7:0] o[$];
        int cut;
        s = frm;
        if (!c_keep) begin
            if (s.size() <= 4) return;
            repeat (4) void'(s.pop_back());
        end
        cut = (c_trim == 2'b01) ? 18 : (c_trim == 2'b10) ? 14 : 0;
        if (s.size() <= cut) return;
        repeat (cut) void'(s.pop_front());
        if (c_t1) begin
            o.push_back(c_t1hi[15:8]); o.push_back(c_t1hi[7:0]);
            o.push_back(c_t1lo[15:8]); o.push_back(c_t1lo[7:0]);
        end
        for (int i = 0; i < s.size(); i++) begin
            o.push_back(s[i]);
            if (c_t2 && cut == 0 && i == 11 && s.size() > 12) begin
                o.push_back(c_t2hi[15:8]); o.push_back(c_t2hi[7:0]);
                o.push_back(c_t2lo[15:8]); o.push_back(c_t2lo[7:0]);
            end
        end
        for (int i = 0; i < o.size(); i++)
            exp_q.push_back({(i == 0), (i == o.size() - 1), o[i]});
    endtask

    task automatic send_frame(int len, int seed, bit midchange);
        bit acc;
        frm.delete();
        for (int i = 0; i < len; i++) frm.push_back(8'(seed * 7 + i * 13 + 1));
        build_expect();
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1; in_data = frm[i];
            in_sof = (i == 0); in_eof = (i == len - 1);
            do begin
                @(negedge clk); acc = in_ready;
                @(posedge clk); #1;
            end while (!acc);
            if (midchange && i == 3) begin
                c_trim = ~c_trim; c_t1 = ~c_t1; c_t2 = ~c_t2; c_keep = ~c_keep;
                c_t1hi = ~c_t1hi; c_t2lo = ~c_t2lo;
            end
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        if (seed % 2 == 1) begin @(posedge clk); #1; end
    endtask

    task automatic compare(string req);
        int bad;
        bad = -1;
        repeat (150) @(posedge clk);
        #1;
        check(obs_q.size() == exp_q.size(), req, "beat count", obs_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
            if (bad < 0 && obs_q[i] !== exp_q[i]) bad = i;
        if (bad >= 0) check(0, req, "beat {sof,eof,data}", obs_q[bad], exp_q[bad]);
        else          check(1, req, "beat content", 0, 0);
        obs_q.delete(); exp_q.delete();
    endtask

    task automatic set_cfg(logic [1:0] tr, bit t1, bit t2, bit keep);
        c_trim = tr; c_t1 = t1; c_t2 = t2; c_keep = keep;
    endtask

    task automatic t_passthrough();  // R1
        set_cfg(2'b00, 0, 0, 1);
        send_frame(20, 1, 0); send_frame(64, 2, 0); send_frame(1, 3, 0);
        compare("R1");
    endtask

    task automatic t_fcs_strip();    // R6
        set_cfg(2'b00, 0, 0, 0);
        send_frame(30, 4, 0); send_frame(5, 5, 0); send_frame(4, 6, 0);
        send_frame(2, 7, 0);
        compare("R6");
    endtask

    task automatic t_trim_long();    // R2, R10
        set_cfg(2'b01, 0, 0, 1);
        send_frame(40, 8, 0); send_frame(19, 9, 0);
        compare("R2");
        send_frame(18, 10, 0); send_frame(3, 11, 0);
        compare("R10");
    endtask

    task automatic t_trim_short();   // R3
        set_cfg(2'b10, 0, 0, 0);
        send_frame(40, 12, 0); send_frame(20, 13, 0);
        compare("R3");
        set_cfg(2'b11, 0, 1, 1);
        send_frame(30, 14, 0);
        compare("R3");
    endtask

    task automatic t_tag1();         // R4
        set_cfg(2'b00, 1, 0, 1);
        send_frame(10, 15, 0); send_frame(1, 16, 0);
        compare("R4");
    endtask

    task automatic t_tag2();         // R5
        set_cfg(2'b00, 0, 1, 1);
        send_frame(13, 17, 0); send_frame(12, 18, 0); send_frame(40, 19, 0);
        compare("R5");
        set_cfg(2'b00, 0, 1, 0);
        send_frame(16, 20, 0); send_frame(17, 21, 0);
        compare("R5");
    endtask

    task automatic t_tag2_skipped(); // R7
        set_cfg(2'b01, 1, 1, 0);
        send_frame(50, 22, 0);
        set_cfg(2'b10, 1, 1, 1);
        send_frame(30, 23, 0);
        compare("R7");
    endtask

    task automatic t_cfg_hold();     // R8
        set_cfg(2'b00, 1, 1, 0);
        send_frame(40, 24, 1);
        send_frame(35, 25, 1);
        compare("R8");
    endtask

    task automatic t_backpressure(); // R9
        bp_on = 1;
        set_cfg(2'b00, 1, 1, 0);
        send_frame(30, 26, 0); send_frame(45, 27, 0);
        set_cfg(2'b01, 1, 0, 0);
        send_frame(60, 28, 0);
        set_cfg(2'b00, 0, 1, 1);
        send_frame(20, 29, 0);
        compare("R9");
        bp_on = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R9 watchdog: actual hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "reset out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R9", "reset in_ready", in_ready, 1);
        @(posedge clk); #1;
        t_passthrough();
        t_fcs_strip();
        t_trim_long();
        t_trim_short();
        t_tag1();
        t_tag2();
        t_tag2_skipped();
        t_cfg_hold();
        t_backpressure();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule